// File: doc/BRIEF.md
# Cooperative Priority Task Scheduler

This block decides which of several hardware tasks owns a shared microcoded processor. Each task has a wakeup line, active low, that its device pulls when it needs service. Task 0 is the background task and always counts as requesting. Among the requesting tasks, the one with the highest index wins. The block drives one active-low ownership line per task and reports the owner's number in binary.

Switching is cooperative. The running task is never displaced while it works. Control can move only when the running task pulses `yield_i`. At that clock edge the scheduler takes a snapshot of the requests and picks the winner. If the winner is a different task, because a higher-priority task is waiting or because the running task has dropped its own request, the current owner keeps the processor for one more cycle and the new owner takes over at the following edge. The running task's code is responsible for getting its own device to drop the wakeup once service is complete.

The usual arrangement is to drive the inputs from logic synchronous to the processor clock and to gate register loads onto the shared bus with the ownership lines.

Top module: `task_sched`

## Requirements
- R1: In the cycle after a synchronous active-high reset, `own_n_o` equals all ones except bit 0 (8'hFE with the default of 8 tasks), and `cur_task_o` is 0.
- R2: In every cycle after reset, exactly one bit of `own_n_o` is low, and it is the bit whose index equals `cur_task_o`.
- R3: If `yield_i` has not been sampled high with a switch resulting, the owner does not change, whatever the wakeup lines do.
- R4: A yield while a task with a higher index is requesting moves ownership to the highest-index requesting task.
- R5: A yield after the owner's own wakeup line has gone high moves ownership to the highest-index task still requesting. This is task 0 if no other task is requesting.
- R6: A yield while the owner still requests and no higher-index task requests leaves the owner unchanged.
- R7: When a yield leads to a switch, the outputs still show the old owner for the first edge after the yield edge. The new owner appears at the edge after that.
- R8: The new owner is chosen from the wakeup lines sampled at the yield edge. Changes to the wakeup lines during the extra cycle do not alter the choice.
- R9: A yield sampled during the extra cycle of a pending switch has no effect.
- R10: `wake_n_i[0]` is ignored, because task 0 always counts as requesting.
- R11: When several tasks request at once, the highest index wins (wake_n bit i belongs to task i).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor clock |
| rst | input | 1 | Synchronous reset, active high |
| wake_n_i | input | NUM_TASKS | Wakeup requests, active low, bit i for task i |
| yield_i | input | 1 | Running task executes its yield function this cycle |
| own_n_o | output | NUM_TASKS | Ownership lines, active low, registered |
| cur_task_o | output | TASK_W | Number of the owning task, registered |

## Verification
Two events can fall in the same cycle: a yield that arms a switch, and a change to the wakeup lines. The reverse case is a wakeup change, or a second yield, during the extra cycle of a pending switch. The bench holds `yield_i` high for two cycles in a row while it swaps which high-priority request is asserted. A reference model driven by the requirements predicts the owner on every clock. The bench then confirms that the target chosen at the first yield edge is kept and that the second yield is ignored.

// File: rtl/task_sched_pkg.sv
package task_sched_pkg;
  localparam int unsigned DEF_TASKS = 8;

  // Active-low one-hot image of a task index
  function automatic logic [31:0] low_hot(input int unsigned idx);
    logic [31:0] v;
    v = '1;
    v[idx] = 1'b0;
    return v;
  endfunction
endpackage

// File: rtl/ts_prio_pick.sv
module ts_prio_pick #(
  parameter int unsigned NUM_TASKS = 8,
  localparam int unsigned TASK_W = $clog2(NUM_TASKS)
) (
  input  logic [NUM_TASKS-1:0] wake_n,
  output logic [TASK_W-1:0]    winner
);
  logic [NUM_TASKS-1:0] req;
  logic [NUM_TASKS-1:0] above;
  logic [NUM_TASKS-1:0] sel;

  // background task always requests
  assign req = {~wake_n[NUM_TASKS-1:1], 1'b1};

  assign above[NUM_TASKS-1] = 1'b0;
  generate
    for (genvar g = NUM_TASKS - 2; g >= 0; g--) begin : g_above
      assign above[g] = above[g+1] | req[g+1];
    end
    for (genvar g = 0; g < NUM_TASKS; g++) begin : g_sel
      assign sel[g] = req[g] & ~above[g];
    end
  endgenerate

  always_comb begin
    winner = '0;
    for (int i = 0; i < NUM_TASKS; i++)
      if (sel[i]) winner = winner | TASK_W'(i);
  end
endmodule

// File: rtl/ts_switch_ctl.sv
module ts_switch_ctl #(
  parameter int unsigned NUM_TASKS = 8,
  localparam int unsigned TASK_W = $clog2(NUM_TASKS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              yield,
  input  logic [TASK_W-1:0] winner,
  output logic [TASK_W-1:0] cur_q,
  output logic [TASK_W-1:0] cur_d
);
  logic              pend_q;
  logic [TASK_W-1:0] tgt_q;
  logic              arm;

  assign arm   = yield && !pend_q && (winner != cur_q);
  assign cur_d = pend_q ? tgt_q : cur_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= 1'b0;
      tgt_q  <= '0;
      cur_q  <= '0;
    end else begin
      cur_q  <= cur_d;
      pend_q <= arm;
      if (arm) tgt_q <= winner;
    end
  end

  // R3
  no_preempt_chk: assert property (@(posedge clk) disable iff (rst)
    !pend_q |=> $stable(cur_q));
  // R9
  single_hold_chk: assert property (@(posedge clk) disable iff (rst)
    pend_q |=> !pend_q);
  // R7
  real_switch_chk: assert property (@(posedge clk) disable iff (rst)
    pend_q |-> (tgt_q != cur_q));
  // R8
  target_keep_chk: assert property (@(posedge clk) disable iff (rst)
    pend_q |=> (cur_q == $past(tgt_q)));
endmodule

// File: rtl/ts_own_decode.sv
module ts_own_decode #(
  parameter int unsigned NUM_TASKS = 8,
  localparam int unsigned TASK_W = $clog2(NUM_TASKS)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [TASK_W-1:0]    cur_d,
  output logic [NUM_TASKS-1:0] own_n_q
);
  import task_sched_pkg::*;

  logic [NUM_TASKS-1:0] own_n_d;

  generate
    for (genvar g = 0; g < NUM_TASKS; g++) begin : g_dec
      assign own_n_d[g] = (cur_d != TASK_W'(g));
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) own_n_q <= NUM_TASKS'(low_hot(0));
    else     own_n_q <= own_n_d;
  end

  // R2
  one_owner_chk: assert property (@(posedge clk) disable iff (rst)
    $countones(~own_n_q) == 1);
endmodule

// File: rtl/task_sched.sv
module task_sched #(
  parameter int unsigned NUM_TASKS = task_sched_pkg::DEF_TASKS,
  localparam int unsigned TASK_W = $clog2(NUM_TASKS)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_TASKS-1:0] wake_n_i,
  input  logic                 yield_i,
  output logic [NUM_TASKS-1:0] own_n_o,
  output logic [TASK_W-1:0]    cur_task_o
);
  logic [TASK_W-1:0] winner;
  logic [TASK_W-1:0] cur_q;
  logic [TASK_W-1:0] cur_d;

  ts_prio_pick #(.NUM_TASKS(NUM_TASKS)) u_pick (
    .wake_n (wake_n_i),
    .winner (winner)
  );

  ts_switch_ctl #(.NUM_TASKS(NUM_TASKS)) u_ctl (
    .clk    (clk),
    .rst    (rst),
    .yield  (yield_i),
    .winner (winner),
    .cur_q  (cur_q),
    .cur_d  (cur_d)
  );

  ts_own_decode #(.NUM_TASKS(NUM_TASKS)) u_dec (
    .clk     (clk),
    .rst     (rst),
    .cur_d   (cur_d),
    .own_n_q (own_n_o)
  );

  assign cur_task_o = cur_q;

  // R2
  owner_match_chk: assert property (@(posedge clk) disable iff (rst)
    own_n_o[cur_task_o] == 1'b0);
endmodule

// File: tb/test_task_sched.sv
module test_task_sched;
  localparam int N = 8;
  localparam int W = 3;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [N-1:0] wake_n = '1;
  logic         yield = 1'b0;
  logic [N-1:0] own_n;
  logic [W-1:0] cur_task;

  int checks = 0;
  int errors = 0;

  // reference model state
  int m_cur = 0;
  bit m_pend = 0;
  int m_tgt = 0;
  bit m_rst_seen = 0;

  always #2.5 clk = ~clk;

  task_sched #(.NUM_TASKS(N)) i_task_sched (
    .clk        (clk),
    .rst        (rst),
    .wake_n_i   (wake_n),
    .yield_i    (yield),
    .own_n_o    (own_n),
    .cur_task_o (cur_task)
  );

  function automatic int best(input logic [N-1:0] w);
    int b = 0;
    for (int i = 1; i < N; i++) if (!w[i]) b = i;
    return b;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // cycle-by-cycle model and comparison
  always @(posedge clk) begin
    logic [N-1:0] exp_own;
    if (rst) begin
      m_cur = 0; m_pend = 0; m_rst_seen = 1;
    end else if (m_pend) begin
      m_cur = m_tgt; m_pend = 0;
    end else if (yield && best(wake_n) != m_cur) begin
      m_pend = 1; m_tgt = best(wake_n);
    end
    #1;
    if (m_rst_seen) begin
      exp_own = '1;
      exp_own[m_cur] = 1'b0;
      check("R2 own_n", int'(own_n), int'(exp_own));
      check("R3/R7 cur_task", int'(cur_task), m_cur);
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(5ns * 20000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    step(3);
    rst = 1'b0;
    // R1 reset state
    check("R1 own_n", int'(own_n), 'hFE);
    check("R1 cur_task", int'(cur_task), 0);

    // R3 requests without yield do not move ownership
    wake_n = 8'b0101_0111;
    step(4);
    check("R3 no preempt", int'(cur_task), 0);

    // R4 + R7: higher request, one yield
    wake_n = 8'b1101_1111;            // task 5
    yield = 1'b1; step(1); yield = 1'b0;
    check("R7 extra cycle", int'(cur_task), 0);
    step(1);
    check("R4 switch to 5", int'(cur_task), 5);
    check("R2 own bit 5", int'(own_n[5]), 0);

    // R6: owner still requests, only lower ones wait
    wake_n = 8'b1101_0111;            // tasks 5 and 3
    yield = 1'b1; step(1); yield = 1'b0;
    step(2);
    check("R6 stays", int'(cur_task), 5);

    // R8 + R9: snapshot at yield edge, second yield ignored
    wake_n = 8'b1001_1111;            // tasks 6 and 5
    yield = 1'b1; step(1);
    wake_n = 8'b0111_1111;            // 6 drops, 7 rises during extra cycle
    step(1); yield = 1'b0;
    check("R8 target kept", int'(cur_task), 6);
    step(2);
    check("R9 second yield ignored", int'(cur_task), 6);

    // R5: owner's request removed
    wake_n = 8'b1111_0111;            // only task 3
    yield = 1'b1; step(1); yield = 1'b0;
    step(1);
    check("R5 falls to 3", int'(cur_task), 3);
    wake_n = 8'b1111_1111;
    yield = 1'b1; step(1); yield = 1'b0;
    step(1);
    check("R5 falls to 0", int'(cur_task), 0);

    // R10: wake_n[0] high, task 0 still owns after yield
    yield = 1'b1; step(1); yield = 1'b0;
    step(2);
    check("R10 task0 keeps", int'(cur_task), 0);
    check("R10 own_n", int'(own_n), 'hFE);

    // R11: several at once
    wake_n = 8'b1110_1001;            // tasks 4,2,1
    yield = 1'b1; step(1); yield = 1'b0;
    step(1);
    check("R11 highest wins", int'(cur_task), 4);

    // R1 again: reset mid-run
    rst = 1'b1; step(1); rst = 1'b0;
    check("R1 after reset", int'(cur_task), 0);
    check("R1 own_n after reset", int'(own_n), 'hFE);
    step(3);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule